// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order processor core built as five stages: fetch, decode with register read, execute, memory access and writeback. Banks of registers separate each neighbouring pair of stages. The decoder generates all control once. That control then rides down the stage registers with the data, and each stage takes only the group of signals it uses. Loads, stores, register-to-register arithmetic and branch-if-equal are all made to take five stages, so every register write lands in the last stage. The single register-file write port is therefore never contended.

Instruction and data memories are small arrays inside the block. They have synchronous write and combinational read. The environment fills them through load ports while reset is held low. Two observation ports return one register and one data word, and the writeback port shows each retiring register write. The core does no forwarding, no stalling and no flushing. Programs must keep at least two unrelated instructions between a producer and its consumer. They must also place three instructions, normally NOPs, after every branch, and those three always complete.

Top module: `pipe5_core`

## Requirements
- R1: While rst_ni is low, the PC reads 0, every stage register holds a bubble (no register write is reported) and all 32 registers read 0.
- R2: Without a taken branch, the PC advances by 4 every cycle, and the fetched word is the instruction memory entry at PC bits [IAW+1:2].
- R3: Opcode bits 31:26 equal to 0 select a register-register operation on registers rs (bits 25:21) and rt (bits 20:16), written to rd (bits 15:11). The function code in bits 5:0 is 32 for add, 34 for subtract, 36 for AND, 37 for OR and 42 for signed set-less-than; any other code adds.
- R4: Opcode 35 (load) reads the data word at rs plus the sign-extended bits 15:0 and writes it to register rt; negative offsets work.
- R5: Opcode 43 (store) writes register rt to the data word at rs plus the sign-extended bits 15:0 and never writes a register.
- R6: Opcode 4 (branch-if-equal) with equal rs and rt redirects fetch to branch PC + 4 + (sign-extended bits 15:0 times 4), starting with the fourth cycle after the branch was fetched. The three instructions fetched behind the branch still complete.
- R7: A branch-if-equal with unequal operands leaves fetch sequential and writes no register.
- R8: Every register write appears on the writeback port and in the register file exactly four cycles after the instruction was fetched, for loads and register-register operations alike.
- R9: Register 0 reads as zero; writes to it are dropped and are not reported on the writeback port.
- R10: A register read in decode during the cycle that writeback writes the same register returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction memory load strobe |
| imem_waddr_i | input | IAW | Instruction memory word index |
| imem_wdata_i | input | 32 | Instruction word to load |
| dmem_we_i | input | 1 | Data memory load strobe (takes priority over stores) |
| dmem_waddr_i | input | DAW | Data memory word index |
| dmem_wdata_i | input | 32 | Data word to load |
| dbg_reg_idx_i | input | 5 | Register to observe |
| dbg_reg_data_o | output | 32 | Observed register value |
| dbg_mem_idx_i | input | DAW | Data word to observe |
| dbg_mem_data_o | output | 32 | Observed data word |
| pc_o | output | 32 | Address being fetched this cycle |
| wb_we_o | output | 1 | A register write retires this cycle |
| wb_idx_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |

## Verification
The bench builds the core with 32 instruction words and 16 data words. This holds the whole test program, with its trailing self-loop, and a data image small enough to be checked in full. A behavioural model runs each instruction as it is fetched and queues its register write four cycles ahead. The bench compares fetch address and writeback on every clock, so the branch shadow, the timing of the redirect and the same-cycle register bypass are all checked at exact cycles.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNCT = 2'd2} alu_sel_e;

  typedef struct packed {
    logic     sext;
    logic     use_imm;
    alu_sel_e alu_sel;
    logic     dst_rd;
  } ex_ctl_t;

  typedef struct packed {
    logic mem_wr;
    logic branch;
  } mem_ctl_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_ctl_t;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc_next;
  } if_id_t;

  typedef struct packed {
    ex_ctl_t         ex;
    mem_ctl_t        mem;
    wb_ctl_t         wb;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [15:0]     imm;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  rd;
    logic [5:0]      funct;
  } id_ex_t;

  typedef struct packed {
    mem_ctl_t        mem;
    wb_ctl_t         wb;
    logic [XLEN-1:0] target;
    logic            zero;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] store;
    logic [RAW-1:0]  dst;
  } ex_mem_t;

  typedef struct packed {
    wb_ctl_t         wb;
    logic [XLEN-1:0] rdata;
    logic [XLEN-1:0] alu;
    logic [RAW-1:0]  dst;
  } mem_wb_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ex_ctl_t    ex_o,
  output mem_ctl_t   mem_o,
  output wb_ctl_t    wb_o
);
  always_comb begin
    ex_o  = '0;
    mem_o = '0;
    wb_o  = '0;
    unique case (opcode_i)
      OP_RTYPE: begin
        ex_o.alu_sel = ALU_FUNCT;
        ex_o.dst_rd  = 1'b1;
        wb_o.reg_wr  = 1'b1;
      end
      OP_LW: begin
        ex_o.sext       = 1'b1;
        ex_o.use_imm    = 1'b1;
        ex_o.alu_sel    = ALU_ADD;
        wb_o.mem_to_reg = 1'b1;
        wb_o.reg_wr     = 1'b1;
      end
      OP_SW: begin
        ex_o.sext    = 1'b1;
        ex_o.use_imm = 1'b1;
        ex_o.alu_sel = ALU_ADD;
        mem_o.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ex_o.sext    = 1'b1;
        ex_o.alu_sel = ALU_SUB;
        mem_o.branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_i,
  input  logic [RAW-1:0]  rb_i,
  input  logic [RAW-1:0]  rc_i,
  output logic [XLEN-1:0] ra_o,
  output logic [XLEN-1:0] rb_o,
  output logic [XLEN-1:0] rc_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // write-through: same-cycle reader sees the value being written
  assign ra_o = (ra_i == '0) ? '0 : (we_i && wa_i == ra_i) ? wd_i : regs_q[ra_i];
  assign rb_o = (rb_i == '0) ? '0 : (we_i && wa_i == rb_i) ? wd_i : regs_q[rb_i];
  assign rc_o = (rc_i == '0) ? '0 : (we_i && wa_i == rc_i) ? wd_i : regs_q[rc_i];

  assert_r0_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);

  assert_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_sel_e        sel_i,
  input  logic [5:0]      funct_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    unique case (sel_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: begin
        unique case (funct_i)
          FN_SUB:  y_o = a_i - b_i;
          FN_AND:  y_o = a_i & b_i;
          FN_OR:   y_o = a_i | b_i;
          FN_SLT:  y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
          default: y_o = a_i + b_i;
        endcase
      end
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_waddr_i,
  input  logic [31:0]     imem_wdata_i,
  input  logic            dmem_we_i,
  input  logic [DAW-1:0]  dmem_waddr_i,
  input  logic [31:0]     dmem_wdata_i,
  input  logic [4:0]      dbg_reg_idx_i,
  output logic [31:0]     dbg_reg_data_o,
  input  logic [DAW-1:0]  dbg_mem_idx_i,
  output logic [31:0]     dbg_mem_data_o,
  output logic [31:0]     pc_o,
  output logic            wb_we_o,
  output logic [4:0]      wb_idx_o,
  output logic [31:0]     wb_data_o
);
  logic [XLEN-1:0] imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  logic [XLEN-1:0] pc_q;
  if_id_t  if_id_q;
  id_ex_t  id_ex_q;
  ex_mem_t ex_mem_q;
  mem_wb_t mem_wb_q;

  // ---------------- IF
  logic [XLEN-1:0] fetch_word, pc_plus4;
  logic            mem_taken;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem_q[imem_waddr_i] <= imem_wdata_i;
  end

  assign fetch_word = imem_q[pc_q[IAW+1:2]];
  assign pc_plus4   = pc_q + 32'd4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      if_id_q <= '0;
    end else begin
      pc_q    <= mem_taken ? ex_mem_q.target : pc_plus4;
      if_id_q <= '{instr: fetch_word, pc_next: pc_plus4};
    end
  end

  // ---------------- ID
  ex_ctl_t         dec_ex;
  mem_ctl_t        dec_mem;
  wb_ctl_t         dec_wb;
  logic [XLEN-1:0] rs_val, rt_val;
  logic            wb_write;
  logic [XLEN-1:0] wb_value;

  pipe5_decode u_decode (
    .opcode_i (if_id_q.instr[31:26]),
    .ex_o     (dec_ex),
    .mem_o    (dec_mem),
    .wb_o     (dec_wb)
  );

  pipe5_regfile u_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (if_id_q.instr[25:21]),
    .rb_i   (if_id_q.instr[20:16]),
    .rc_i   (dbg_reg_idx_i),
    .ra_o   (rs_val),
    .rb_o   (rt_val),
    .rc_o   (dbg_reg_data_o),
    .we_i   (wb_write),
    .wa_i   (mem_wb_q.dst),
    .wd_i   (wb_value)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_ex_q <= '0;
    end else begin
      id_ex_q.ex      <= dec_ex;
      id_ex_q.mem     <= dec_mem;
      id_ex_q.wb      <= dec_wb;
      id_ex_q.pc_next <= if_id_q.pc_next;
      id_ex_q.opa     <= rs_val;
      id_ex_q.opb     <= rt_val;
      id_ex_q.imm     <= if_id_q.instr[15:0];
      id_ex_q.rt      <= if_id_q.instr[20:16];
      id_ex_q.rd      <= if_id_q.instr[15:11];
      id_ex_q.funct   <= if_id_q.instr[5:0];
    end
  end

  // ---------------- EX
  logic [XLEN-1:0] imm_ext, alu_b, alu_y;
  logic            alu_zero;

  assign imm_ext = id_ex_q.ex.sext ? {{(XLEN-16){id_ex_q.imm[15]}}, id_ex_q.imm}
                                   : {{(XLEN-16){1'b0}}, id_ex_q.imm};
  assign alu_b   = id_ex_q.ex.use_imm ? imm_ext : id_ex_q.opb;

  pipe5_alu u_alu (
    .a_i     (id_ex_q.opa),
    .b_i     (alu_b),
    .sel_i   (id_ex_q.ex.alu_sel),
    .funct_i (id_ex_q.funct),
    .y_o     (alu_y),
    .zero_o  (alu_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_mem_q <= '0;
    end else begin
      ex_mem_q.mem    <= id_ex_q.mem;
      ex_mem_q.wb     <= id_ex_q.wb;
      ex_mem_q.target <= id_ex_q.pc_next + {imm_ext[XLEN-3:0], 2'b00};
      ex_mem_q.zero   <= alu_zero;
      ex_mem_q.alu    <= alu_y;
      ex_mem_q.store  <= id_ex_q.opb;
      ex_mem_q.dst    <= id_ex_q.ex.dst_rd ? id_ex_q.rd : id_ex_q.rt;
    end
  end

  // ---------------- MEM
  logic [DAW-1:0]  dmem_idx;
  logic [XLEN-1:0] load_word;

  assign mem_taken = ex_mem_q.mem.branch && ex_mem_q.zero;
  assign dmem_idx  = ex_mem_q.alu[DAW+1:2];
  assign load_word = dmem_q[dmem_idx];

  always_ff @(posedge clk_i) begin
    if (dmem_we_i)                 dmem_q[dmem_waddr_i] <= dmem_wdata_i;
    else if (ex_mem_q.mem.mem_wr) dmem_q[dmem_idx]     <= ex_mem_q.store;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wb_q <= '0;
    end else begin
      mem_wb_q.wb    <= ex_mem_q.wb;
      mem_wb_q.rdata <= load_word;
      mem_wb_q.alu   <= ex_mem_q.alu;
      mem_wb_q.dst   <= ex_mem_q.dst;
    end
  end

  // ---------------- WB
  assign wb_write = mem_wb_q.wb.reg_wr;
  assign wb_value = mem_wb_q.wb.mem_to_reg ? mem_wb_q.rdata : mem_wb_q.alu;

  assign pc_o           = pc_q;
  assign wb_we_o        = wb_write && (mem_wb_q.dst != '0);
  assign wb_idx_o       = mem_wb_q.dst;
  assign wb_data_o      = wb_value;
  assign dbg_mem_data_o = dmem_q[dbg_mem_idx_i];

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_taken |=> pc_q == $past(pc_q) + 32'd4);

  assert_branch_redirect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_taken |=> pc_q == $past(ex_mem_q.target));

  assert_store_no_regwr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_mem_q.mem.mem_wr |=> !mem_wb_q.wb.reg_wr);
endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
  localparam int IW  = 32;
  localparam int DW  = 16;
  localparam int IAW = $clog2(IW);
  localparam int DAW = $clog2(DW);
  localparam int RUN_CYCLES = 80;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            imem_we_i = 1'b0;
  logic [IAW-1:0]  imem_waddr_i = '0;
  logic [31:0]     imem_wdata_i = '0;
  logic            dmem_we_i = 1'b0;
  logic [DAW-1:0]  dmem_waddr_i = '0;
  logic [31:0]     dmem_wdata_i = '0;
  logic [4:0]      dbg_reg_idx_i = '0;
  logic [31:0]     dbg_reg_data_o;
  logic [DAW-1:0]  dbg_mem_idx_i = '0;
  logic [31:0]     dbg_mem_data_o;
  logic [31:0]     pc_o;
  logic            wb_we_o;
  logic [4:0]      wb_idx_o;
  logic [31:0]     wb_data_o;

  always #2.5 clk = ~clk;

  pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_we_i(imem_we_i), .imem_waddr_i(imem_waddr_i), .imem_wdata_i(imem_wdata_i),
    .dmem_we_i(dmem_we_i), .dmem_waddr_i(dmem_waddr_i), .dmem_wdata_i(dmem_wdata_i),
    .dbg_reg_idx_i(dbg_reg_idx_i), .dbg_reg_data_o(dbg_reg_data_o),
    .dbg_mem_idx_i(dbg_mem_idx_i), .dbg_mem_data_o(dbg_mem_data_o),
    .pc_o(pc_o), .wb_we_o(wb_we_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // behavioural reference state
  logic [31:0] img  [IW];
  logic [31:0] mreg [32];
  logic [31:0] mmem [DW];
  logic [31:0] mpc = '0;
  int          br_cnt = 0;
  logic [31:0] br_tgt = '0;
  logic        q_we  [4];
  logic [4:0]  q_idx [4];
  logic [31:0] q_dat [4];

  task automatic model_step();
    logic [31:0] ins, a, b, sx, res;
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd;
    logic        ev_we = 1'b0;
    logic [4:0]  ev_idx = '0;
    logic [31:0] ev_dat = '0;
    ins = img[(mpc >> 2) % IW];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = mreg[rs]; b = mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    case (op)
      6'd0: begin
        case (ins[5:0])
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = a + b;
        endcase
        if (rd != 0) begin ev_we = 1; ev_idx = rd; ev_dat = res; end
      end
      6'd35: begin
        res = mmem[((a + sx) >> 2) % DW];
        if (rt != 0) begin ev_we = 1; ev_idx = rt; ev_dat = res; end
      end
      6'd43: mmem[((a + sx) >> 2) % DW] = b;
      6'd4: if (a == b) begin br_cnt = 4; br_tgt = mpc + 4 + (sx << 2); end
      default: ;
    endcase
    if (ev_we) mreg[ev_idx] = ev_dat;
    for (int i = 3; i > 0; i--) begin
      q_we[i] = q_we[i-1]; q_idx[i] = q_idx[i-1]; q_dat[i] = q_dat[i-1];
    end
    q_we[0] = ev_we; q_idx[0] = ev_idx; q_dat[0] = ev_dat;
    if (br_cnt > 0) br_cnt--;
    if (br_tgt !== '0 && br_cnt == 0 && op == 6'd4 && a == b && 0) ;
    mpc = (br_cnt == 0 && br_tgt !== 32'hFFFF_FFFF && pending) ? br_tgt : mpc + 4;
    if (pending && br_cnt == 0) pending = 0;
    if (op == 6'd4 && a == b) pending = 1;
  endtask

  bit pending = 0;

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < IW; i++) img[i] = '0;
    img[0]  = enc_i(35, 0, 1, 0);
    img[1]  = enc_i(35, 0, 2, 4);
    img[2]  = enc_i(35, 0, 3, 8);
    img[5]  = enc_r(1, 2, 4, 32);
    img[6]  = enc_r(1, 3, 5, 34);
    img[7]  = enc_r(1, 2, 6, 36);
    img[8]  = enc_r(1, 3, 7, 37);
    img[9]  = enc_r(3, 1, 8, 42);
    img[10] = enc_r(1, 2, 0, 32);
    img[11] = enc_i(43, 0, 4, 12);
    img[12] = enc_i(43, 0, 6, 20);
    img[13] = enc_i(35, 4, 10, -4);
    img[14] = enc_i(4, 1, 1, 7);
    for (int i = 18; i < 22; i++) img[i] = enc_r(1, 1, 11, 32);
    img[22] = enc_i(4, 1, 2, 1);
    img[23] = enc_r(1, 2, 13, 32);
    img[26] = enc_r(13, 13, 14, 32);
    img[27] = enc_i(43, 0, 8, 16);
    img[28] = enc_i(4, 0, 0, -1);
    for (int i = 0; i < DW; i++) mmem[i] = '0;
    mmem[0] = 32'd5; mmem[1] = 32'd7; mmem[2] = 32'hFFFF_FFFD; mmem[3] = 32'h1234;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int i = 0; i < 4; i++) begin q_we[i] = 0; q_idx[i] = '0; q_dat[i] = '0; end

    repeat (2) @(negedge clk);
    // R1: reset state
    dbg_reg_idx_i = 5'd5;
    #1;
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 no writeback in reset", {31'd0, wb_we_o}, 32'd0);
    chk("R1 register cleared", dbg_reg_data_o, 32'd0);

    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_we_i = 1; imem_waddr_i = IAW'(i); imem_wdata_i = img[i];
    end
    for (int i = 0; i < DW; i++) begin
      @(negedge clk);
      imem_we_i = 0;
      dmem_we_i = 1; dmem_waddr_i = DAW'(i); dmem_wdata_i = mmem[i];
    end
    @(negedge clk);
    dmem_we_i = 0;
    chk("R1 pc held during load", pc_o, 32'd0);
    rst_ni = 1;

    for (int c = 0; c < RUN_CYCLES; c++) begin
      #1;
      chk("R2/R6 fetch address", pc_o, mpc);
      chk("R8 writeback strobe", {31'd0, wb_we_o}, {31'd0, q_we[3]});
      if (q_we[3]) begin
        chk("R8 writeback index", {27'd0, wb_idx_o}, {27'd0, q_idx[3]});
        chk("R8 writeback data", wb_data_o, q_dat[3]);
      end
      model_step();
      @(negedge clk);
    end

    // final architectural state, values derived by hand from the requirements
    begin
      logic [31:0] exp_r [15];
      exp_r = '{32'd0, 32'd5, 32'd7, 32'hFFFF_FFFD, 32'd12, 32'd8, 32'd5,
                32'hFFFF_FFFD, 32'd1, 32'd0, 32'hFFFF_FFFD, 32'd0, 32'd0, 32'd12, 32'd24};
      for (int r = 0; r < 15; r++) begin
        dbg_reg_idx_i = 5'(r);
        #1;
        chk($sformatf("R3/R4 reg %0d", r), dbg_reg_data_o, exp_r[r]);
        chk($sformatf("R8 model reg %0d", r), dbg_reg_data_o, mreg[r]);
      end
    end
    dbg_reg_idx_i = 5'd0;  #1; chk("R9 r0 ignores add into r0", dbg_reg_data_o, 32'd0);
    dbg_reg_idx_i = 5'd10; #1; chk("R4 load with negative offset", dbg_reg_data_o, 32'hFFFF_FFFD);
    dbg_reg_idx_i = 5'd11; #1; chk("R6 skipped instruction never writes", dbg_reg_data_o, 32'd0);
    dbg_reg_idx_i = 5'd13; #1; chk("R7 fall-through after untaken branch", dbg_reg_data_o, 32'd12);
    dbg_reg_idx_i = 5'd14; #1; chk("R10 same-cycle bypass", dbg_reg_data_o, 32'd24);
    dbg_reg_idx_i = 5'd9;  #1; chk("R5 store wrote no register", dbg_reg_data_o, 32'd0);
    dbg_mem_idx_i = DAW'(3); #1; chk("R5 store word 3", dbg_mem_data_o, 32'd12);
    dbg_mem_idx_i = DAW'(5); #1; chk("R5 store word 5", dbg_mem_data_o, 32'd5);
    dbg_mem_idx_i = DAW'(4); #1; chk("R5 store word 4", dbg_mem_data_o, 32'd1);
    dbg_mem_idx_i = DAW'(0); #1; chk("R4 load source untouched", dbg_mem_data_o, 32'd5);
    for (int i = 0; i < DW; i++) begin
      dbg_mem_idx_i = DAW'(i);
      #1;
      chk($sformatf("R5 model data word %0d", i), dbg_mem_data_o, mmem[i]);
    end
    done = 1;
    report();
  end
endmodule